// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block gathers the interrupt state of a bank of countdown timers into one word. Each channel owns an enable bit and a sticky status flag. Each time the counter bank reports that a channel has expired, that channel's status flag is set. When the channel's enable is also set, its interrupt line is raised as well. Software reads the whole word and acknowledges a channel by writing 1 to its status bit. That write clears the flag and drops the matching line.

A single write port updates the register. The low field of the written word replaces the enables. The field above it is a write-1-to-clear mask for the status flags. The register contents are always visible on the read bus, and the interrupt lines are registered outputs. An expiry and an acknowledge that meet in the same cycle are settled in favour of the expiry, so that no event is lost.

Top module: `irq_status_ctrl`

## Requirements
- R1: With NUM_CH = 5, the enable of channel i is at rd_data bit i and the status of channel i is at rd_data bit 5+i. The register value appears on rd_data in the cycle after the edge that updates it.
- R2: A pulse on expire[i] sets status bit i at the next edge, whatever the enable of channel i.
- R3: irq[i] rises at the edge that samples expire[i] only if enable i held 1 before that edge. An enable written in the same cycle as the expiry does not count.
- R4: A write loads wr_data[4:0] into the enables.
- R5: A write with wr_data[5+i] = 1 clears status bit i and drops irq[i] at the next edge. A write with wr_data[5+i] = 0 leaves status bit i and irq[i] unchanged.
- R6: Reset (synchronous, active high) sets every enable, status bit and line to 0.
- R7: When expire[i] and a clear of status bit i arrive in the same cycle, status bit i stays 1 and irq[i] does not fall.
- R8: Setting an enable while its status bit is already 1 does not raise irq[i].
- R9: rd_data bits above 9 always read 0, and written values in those bits have no effect.
- R10: Writing an enable to 0 does not lower an irq line that is already high. Only a status clear lowers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write word: enables in the low field, clear mask in the next field |
| expire | input | NUM_CH | One-cycle expiry pulse for each channel from the counter bank |
| rd_data | output | DATA_W | Current register value |
| irq | output | NUM_CH | Interrupt line for each channel |

## Verification
The hardest cases to reach involve one cycle that carries both a write and an expiry. In one such case the write tries to clear the status of a channel that expires in that cycle. In the other, the write enables a channel whose expiry arrives in that cycle. The stimulus table puts the write and the expiry pulse in the same row, so both are driven before a single clock edge. Before those rows, the table leaves a line high and a status flag pending, so the expected result separates "line held" from "line freshly raised".

// File: rtl/tint_pkg.sv
`timescale 1ns/1ps
package tint_pkg;

    localparam int unsigned DEF_NUM_CH = 5;
    localparam int unsigned DEF_DATA_W = 32;

    // What happens to one status flag in a cycle
    typedef enum logic [1:0] {
        EV_HOLD     = 2'd0,
        EV_SET      = 2'd1,
        EV_CLEAR    = 2'd2,
        EV_SET_WINS = 2'd3
    } stat_ev_e;

    // State held per channel
    typedef struct packed {
        logic en;
        logic stat;
        logic line;
    } ch_state_t;

    function automatic stat_ev_e classify_ev(input logic hit, input logic clr);
        if (hit && clr)
            return EV_SET_WINS;
        else if (hit)
            return EV_SET;
        else if (clr)
            return EV_CLEAR;
        return EV_HOLD;
    endfunction

endpackage

// File: rtl/irq_wr_decode.sv
`timescale 1ns/1ps
module irq_wr_decode #(
    parameter int unsigned NUM_CH = tint_pkg::DEF_NUM_CH
) (
    input  logic                wr_en,
    input  logic [2*NUM_CH-1:0] wr_field,
    output logic                en_load,
    output logic [NUM_CH-1:0]   en_value,
    output logic [NUM_CH-1:0]   clr_mask
);
    localparam int unsigned STAT_LSB = NUM_CH;

    always_comb begin
        en_load  = wr_en;
        en_value = wr_field[NUM_CH-1:0];
        clr_mask = wr_en ? wr_field[STAT_LSB +: NUM_CH] : '0;
    end
endmodule

// File: rtl/irq_channel_slice.sv
`timescale 1ns/1ps
module irq_channel_slice
    import tint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_load,
    input  logic en_wr,
    input  logic clr_wr,
    input  logic expire,
    output logic en_q,
    output logic stat_q,
    output logic line_q
);
    ch_state_t cur, nxt;
    stat_ev_e  ev;

    always_comb begin
        ev       = classify_ev(expire, clr_wr);
        nxt      = cur;
        nxt.en   = en_load ? en_wr : cur.en;
        unique case (ev)
            EV_SET, EV_SET_WINS: nxt.stat = 1'b1;
            EV_CLEAR:            nxt.stat = 1'b0;
            default:             nxt.stat = cur.stat;
        endcase
        if (expire && cur.en)
            nxt.line = 1'b1;
        else if (ev == EV_CLEAR)
            nxt.line = 1'b0;
        else
            nxt.line = cur.line;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= nxt;
    end

    assign en_q   = cur.en;
    assign stat_q = cur.stat;
    assign line_q = cur.line;

    // R2
    stat_on_expire_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> stat_q);
    // R3
    line_on_enabled_expire_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && en_q) |=> line_q);
    // R4
    enable_load_chk: assert property (@(posedge clk) disable iff (rst)
        en_load |=> (en_q == $past(en_wr)));
    // R5
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !expire) |=> (!stat_q && !line_q));
    // R7
    expire_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && clr_wr) |=> stat_q);
    // R8
    no_spurious_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_q && !expire) |=> !line_q);
    // R10
    line_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (line_q && !clr_wr) |=> line_q);
    // R5
    line_implies_stat_chk: assert property (@(posedge clk) disable iff (rst)
        line_q |-> stat_q);
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl #(
    parameter int unsigned NUM_CH = tint_pkg::DEF_NUM_CH,
    parameter int unsigned DATA_W = tint_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] expire,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] irq
);
    localparam int unsigned STAT_LSB = NUM_CH;
    localparam int unsigned USED_W   = 2 * NUM_CH;

    logic              en_load;
    logic [NUM_CH-1:0] en_value;
    logic [NUM_CH-1:0] clr_mask;
    logic [NUM_CH-1:0] en_bits;
    logic [NUM_CH-1:0] stat_bits;

    irq_wr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .wr_en    (wr_en),
        .wr_field (wr_data[USED_W-1:0]),
        .en_load  (en_load),
        .en_value (en_value),
        .clr_mask (clr_mask)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        irq_channel_slice u_slice (
            .clk     (clk),
            .rst     (rst),
            .en_load (en_load),
            .en_wr   (en_value[g]),
            .clr_wr  (clr_mask[g]),
            .expire  (expire[g]),
            .en_q    (en_bits[g]),
            .stat_q  (stat_bits[g]),
            .line_q  (irq[g])
        );
    end

    always_comb begin
        rd_data                         = '0;
        rd_data[NUM_CH-1:0]             = en_bits;
        rd_data[STAT_LSB +: NUM_CH]     = stat_bits;
    end

    if (DATA_W > USED_W) begin : g_hi
        // R9
        upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
            rd_data[DATA_W-1:USED_W] == '0);
    end

    // R1
    irq_within_status_chk: assert property (@(posedge clk) disable iff (rst)
        (irq & ~rd_data[STAT_LSB +: NUM_CH]) == '0);
endmodule

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
    localparam int NCH = 5;
    localparam int DW  = 32;

    typedef struct packed {
        logic        wr;
        logic [31:0] wdata;
        logic [4:0]  exp;
        logic [31:0] rd;
        logic [4:0]  irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 32'h0000_001F, 5'b00000, 32'h01F, 5'b00000, 8'd4},  // R4 enable all
        '{1'b0, 32'h0,         5'b00001, 32'h03F, 5'b00001, 8'd3},  // R3 ch0 fires
        '{1'b1, 32'h0000_0004, 5'b00000, 32'h024, 5'b00001, 8'd10}, // R10 disable ch0, line held
        '{1'b0, 32'h0,         5'b00011, 32'h064, 5'b00001, 8'd2},  // R2 status without enable
        '{1'b1, 32'h0000_0024, 5'b00000, 32'h044, 5'b00000, 8'd5},  // R5 clear ch0
        '{1'b1, 32'h0000_0006, 5'b00000, 32'h046, 5'b00000, 8'd8},  // R8 enable ch1 while pending
        '{1'b0, 32'h0,         5'b00100, 32'h0C6, 5'b00100, 8'd3},  // R3 ch2 fires
        '{1'b1, 32'hFFFF_FC06, 5'b00000, 32'h0C6, 5'b00100, 8'd9},  // R9 upper bits ignored
        '{1'b1, 32'h0000_0086, 5'b00100, 32'h0C6, 5'b00100, 8'd7},  // R7 clear and expire ch2
        '{1'b1, 32'h0000_00C6, 5'b00000, 32'h006, 5'b00000, 8'd5},  // R5 clear ch1 and ch2
        '{1'b1, 32'h0000_001F, 5'b10000, 32'h21F, 5'b00000, 8'd3},  // R3 enable in same cycle is late
        '{1'b0, 32'h0,         5'b11111, 32'h3FF, 5'b11111, 8'd1},  // R1 full layout
        '{1'b1, 32'h0000_03E0, 5'b00000, 32'h000, 5'b00000, 8'd5}   // R5 clear all, R4 enables off
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic [NCH-1:0] expire;
    logic [DW-1:0] rd_data;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_status_ctrl #(.NUM_CH(NCH), .DATA_W(DW)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .expire  (expire),
        .rd_data (rd_data),
        .irq     (irq)
    );

    task automatic step(input logic w, input logic [31:0] d, input logic [4:0] e);
        @(negedge clk);
        wr_en   = w;
        wr_data = d;
        expire  = e;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
        wr_data = '0;
        expire  = '0;
    endtask

    task automatic check(input int req, input logic [31:0] exp_rd, input logic [4:0] exp_irq);
        checks++;
        if (rd_data !== exp_rd || irq !== exp_irq) begin
            errors++;
            $display("FAIL R%0d: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     req, rd_data, irq, exp_rd, exp_irq);
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; expire = '0;
        repeat (2) @(posedge clk);
        #1;
        check(6, 32'h0, 5'b0);              // R6 state after reset
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].wr, VEC[i].wdata, VEC[i].exp);
            check(int'(VEC[i].req), VEC[i].rd, VEC[i].irq);
        end

        // R6 reset clears pending state and lines
        step(1'b1, 32'h1F, 5'b00000);
        step(1'b0, 32'h0, 5'b11111);
        check(3, 32'h3FF, 5'b11111);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(6, 32'h0, 5'b0);
        @(negedge clk);
        rst = 1'b0;

        // R5 write of zeros in status field leaves pending state alone
        step(1'b1, 32'h01, 5'b00001);
        check(3, 32'h021, 5'b00000);
        step(1'b0, 32'h0, 5'b00001);
        check(3, 32'h021, 5'b00001);
        step(1'b1, 32'h01, 5'b00000);
        check(5, 32'h021, 5'b00001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule